// File: doc/BRIEF.md
# Streaming Covariance Engine

This block computes the population covariance of two equal-length arrays of unsigned 8-bit samples that sit in a byte-wide data memory. It waits for a falling edge on `start` and then reads the sample count from address 0. It fetches each X sample together with its matching Y sample and keeps three running sums: Σx, Σy and Σx·y. From these it forms the exact integer numerator N·Σxy − Σx·Σy. A serial divider scales that numerator by 256 and divides it by N², rounding to the nearest value. The block then writes the 8.8 fixed-point result directly after the two arrays and raises `done` for two cycles.

The memory is reached through one shared request channel that carries reads and writes and uses valid/ready. Read data comes back on a separate response channel. The engine keeps issuing reads while earlier reads are still outstanding, so a memory that accepts one request per cycle and answers in order can stream one sample per cycle. Back-pressure rules: a request stays asserted with a stable address, write flag and write data until it is accepted. The memory must return exactly one response per accepted read, in acceptance order, no earlier than the cycle after acceptance. The engine always accepts responses, so the response channel has no ready. Writes produce no response.

Top module: `cov_engine`

## Requirements
- R1: A run starts only when `start` is seen low in a cycle after it was seen high. Further `start` edges during a run are ignored. No request is issued outside a run.
- R2: The first request of a run is a read of address 0. It returns N, where the byte value 0 stands for N = 256.
- R3: After N is known, reads follow the order address 1, N+1, 2, N+2, …, N, 2N. Element i of X is at address i and element i of Y is at address N+i.
- R4: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays asserted and its address, write flag and write data do not change.
- R5: Read data is taken from `mem_rsp_valid`/`mem_rsp_rdata` in the order the reads were accepted, and any response latency of one cycle or more gives the same result.
- R6: The result is the population covariance times 256, rounded to nearest with halves rounded up. Its upper byte is written to address 2N+1, then its lower byte to address 2N+2, as the only two writes of the run.
- R7: When Σ(x−x̄)(y−ȳ) is negative, both result bytes are 0x00.
- R8: When the rounded result exceeds 0xFFFF, both result bytes are 0xFF.
- R9: `done` is high for exactly two cycles, starting in the cycle after the second write is accepted. No request is issued while `done` is high.
- R10: After reset, `done` and `mem_req_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch control; a falling edge starts a run |
| done | output | 1 | High for two cycles when a run has finished |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | AW (10) | Byte address |
| mem_req_wdata | output | DW (8) | Write data |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_rdata | input | DW (8) | Read data |

## Verification
A wrong sample count or a fetch counter out of step shows up on the request address in the very next accepted read, because every read address is compared with its expected position in the interleaved order. A corrupted accumulator or divider state does not appear at the ports until the first result write, and then it appears as a wrong byte value. Stimulus for these faults therefore includes short runs, a full 256-sample run, negative and saturating results, and random stalls on both channels. A state machine stuck in its last phase shows up as `done` lasting the wrong number of cycles, or as a request while `done` is high.

// File: rtl/cov_pkg.sv
package cov_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_NREQ,
    ST_NWAIT,
    ST_FETCH,
    ST_CALC,
    ST_DIV,
    ST_WINT,
    ST_WFRAC,
    ST_DONE
  } cov_state_t;
endpackage

// File: rtl/cov_accum.sv
// Running sums for paired samples: x is held until its y partner arrives.
module cov_accum #(
  parameter int DW = 8,
  parameter int NW = DW + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   x_en,
  input  logic                   y_en,
  input  logic [DW-1:0]          din,
  output logic [DW+NW-1:0]       sum_x,
  output logic [DW+NW-1:0]       sum_y,
  output logic [2*DW+NW-1:0]     sum_xy
);
  localparam int SX_W  = DW + NW;
  localparam int SXY_W = 2 * DW + NW;

  logic [DW-1:0]   x_hold;
  logic [2*DW-1:0] prod;

  assign prod = x_hold * din;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_hold <= '0;
      sum_x  <= '0;
      sum_y  <= '0;
      sum_xy <= '0;
    end else if (clr) begin
      x_hold <= '0;
      sum_x  <= '0;
      sum_y  <= '0;
      sum_xy <= '0;
    end else begin
      if (x_en) begin
        x_hold <= din;
        sum_x  <= sum_x + SX_W'(din);
      end
      if (y_en) begin
        sum_y  <= sum_y + SX_W'(din);
        sum_xy <= sum_xy + SXY_W'(prod);
      end
    end
  end
endmodule

// File: rtl/cov_div.sv
// Serial restoring divider, one quotient bit per cycle.
module cov_div #(
  parameter int DVD_W = 43,
  parameter int DVS_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [DVD_W-1:0] dividend,
  input  logic [DVS_W-1:0] divisor,
  output logic             fin,
  output logic [DVD_W-1:0] quot
);
  localparam int CNT_W = $clog2(DVD_W + 1);

  logic [DVD_W-1:0] dvd_sh;
  logic [DVS_W-1:0] rem, dvs_r;
  logic [CNT_W-1:0] left;
  logic [DVS_W:0]   trial, diff;
  logic             ge;

  assign trial = {rem, dvd_sh[DVD_W-1]};
  assign ge    = trial >= {1'b0, dvs_r};
  assign diff  = trial - {1'b0, dvs_r};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dvd_sh <= '0;
      dvs_r  <= '0;
      rem    <= '0;
      quot   <= '0;
      left   <= '0;
      fin    <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        dvd_sh <= dividend;
        dvs_r  <= divisor;
        rem    <= '0;
        quot   <= '0;
        left   <= CNT_W'(DVD_W);
      end else if (left != '0) begin
        dvd_sh <= dvd_sh << 1;
        rem    <= ge ? diff[DVS_W-1:0] : trial[DVS_W-1:0];
        quot   <= {quot[DVD_W-2:0], ge};
        left   <= left - 1'b1;
        if (left == CNT_W'(1)) fin <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/cov_engine.sv
module cov_engine #(
  parameter int DW = 8,
  parameter int AW = $clog2(2 * (2 ** DW) + 3)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          done,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_we,
  output logic [AW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_rdata
);
  import cov_pkg::*;

  localparam int NW    = DW + 1;          // holds N up to 2**DW
  localparam int CW    = NW + 1;          // counts up to 2N
  localparam int SX_W  = DW + NW;
  localparam int SXY_W = 2 * DW + NW;
  localparam int NUM_W = SXY_W + NW + 1;
  localparam int DVD_W = NUM_W + DW;
  localparam int DVS_W = 2 * NW;
  localparam int RW    = 2 * DW;

  cov_state_t st;
  logic          start_q, launch, done_ph;
  logic [NW-1:0] n_r, idx;
  logic [CW-1:0] req_cnt, rsp_cnt, two_n;
  logic [RW-1:0] res;

  logic              acc_clr, x_en, y_en;
  logic [SX_W-1:0]   sum_x, sum_y;
  logic [SXY_W-1:0]  sum_xy;
  logic [NUM_W-1:0]  prod_a, prod_b, num;
  logic [DVS_W-1:0]  nsq;
  logic [DVD_W-1:0]  dvd, quot;
  logic              neg, div_go, div_fin, sat, hs;

  assign launch = start_q & ~start;
  assign two_n  = {n_r, 1'b0};
  assign idx    = req_cnt[CW-1:1];
  assign hs     = mem_req_valid & mem_req_ready;

  // exact numerator N*Sxy - Sx*Sy, scaled by 256, plus half of N^2 for rounding
  assign prod_a = NUM_W'(n_r) * NUM_W'(sum_xy);
  assign prod_b = NUM_W'(sum_x) * NUM_W'(sum_y);
  assign neg    = prod_b > prod_a;
  assign num    = prod_a - prod_b;
  assign nsq    = DVS_W'(n_r) * DVS_W'(n_r);
  assign dvd    = {num, {DW{1'b0}}} + DVD_W'(nsq >> 1);
  assign div_go = (st == ST_CALC) && !neg;
  assign sat    = |quot[DVD_W-1:RW];

  assign acc_clr = (st == ST_NWAIT) && mem_rsp_valid;
  assign x_en    = (st == ST_FETCH) && mem_rsp_valid && !rsp_cnt[0];
  assign y_en    = (st == ST_FETCH) && mem_rsp_valid &&  rsp_cnt[0];

  cov_accum #(.DW(DW), .NW(NW)) u_acc (
    .clk(clk), .rst_n(rst_n), .clr(acc_clr), .x_en(x_en), .y_en(y_en),
    .din(mem_rsp_rdata), .sum_x(sum_x), .sum_y(sum_y), .sum_xy(sum_xy)
  );

  cov_div #(.DVD_W(DVD_W), .DVS_W(DVS_W)) u_div (
    .clk(clk), .rst_n(rst_n), .go(div_go), .dividend(dvd), .divisor(nsq),
    .fin(div_fin), .quot(quot)
  );

  always_comb begin
    mem_req_valid = 1'b0;
    mem_req_we    = 1'b0;
    mem_req_addr  = '0;
    mem_req_wdata = '0;
    done          = 1'b0;
    unique case (st)
      ST_NREQ:  mem_req_valid = 1'b1;
      ST_FETCH: begin
        mem_req_valid = req_cnt < two_n;
        mem_req_addr  = req_cnt[0] ? AW'(n_r) + AW'(idx) + AW'(1)
                                   : AW'(idx) + AW'(1);
      end
      ST_WINT: begin
        mem_req_valid = 1'b1;
        mem_req_we    = 1'b1;
        mem_req_addr  = AW'(two_n) + AW'(1);
        mem_req_wdata = res[RW-1:DW];
      end
      ST_WFRAC: begin
        mem_req_valid = 1'b1;
        mem_req_we    = 1'b1;
        mem_req_addr  = AW'(two_n) + AW'(2);
        mem_req_wdata = res[DW-1:0];
      end
      ST_DONE: done = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      start_q <= 1'b0;
      n_r     <= '0;
      req_cnt <= '0;
      rsp_cnt <= '0;
      res     <= '0;
      done_ph <= 1'b0;
    end else begin
      start_q <= start;
      unique case (st)
        ST_IDLE:  if (launch) st <= ST_NREQ;
        ST_NREQ:  if (hs) st <= ST_NWAIT;
        ST_NWAIT: if (mem_rsp_valid) begin
          n_r     <= (mem_rsp_rdata == '0) ? NW'(2 ** DW) : NW'(mem_rsp_rdata);
          req_cnt <= '0;
          rsp_cnt <= '0;
          st      <= ST_FETCH;
        end
        ST_FETCH: begin
          if (hs) req_cnt <= req_cnt + 1'b1;
          if (mem_rsp_valid) begin
            rsp_cnt <= rsp_cnt + 1'b1;
            if (rsp_cnt == two_n - 1'b1) st <= ST_CALC;
          end
        end
        ST_CALC: begin
          if (neg) begin
            res <= '0;
            st  <= ST_WINT;
          end else begin
            st  <= ST_DIV;
          end
        end
        ST_DIV: if (div_fin) begin
          res <= sat ? {RW{1'b1}} : quot[RW-1:0];
          st  <= ST_WINT;
        end
        ST_WINT:  if (hs) st <= ST_WFRAC;
        ST_WFRAC: if (hs) begin
          done_ph <= 1'b0;
          st      <= ST_DONE;
        end
        ST_DONE: begin
          done_ph <= 1'b1;
          if (done_ph) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cov_engine_chk.sv
module cov_engine_chk #(
  parameter int DW = 8,
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          done,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic          mem_req_we,
  input logic [AW-1:0] mem_req_addr,
  input logic [DW-1:0] mem_req_wdata
);
  // R4: stalled request holds all its fields
  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we) && $stable(mem_req_wdata)));

  // R9: done lasts at least two cycles once raised
  p_done_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |=> done);

  // R9: done lasts no more than two cycles
  p_done_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(done)) |=> !done);

  // R9: memory is left alone while done is shown
  p_done_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req_valid);

  // R6: writes only land past the sample arrays (2N+1 >= 3)
  p_wr_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_we) |-> (mem_req_addr >= AW'(3)));

  // R3: reads never go beyond address 2N of the largest N
  p_rd_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_we) |-> (mem_req_addr <= AW'(2 * (2 ** DW))));
endmodule

bind cov_engine cov_engine_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
  .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata)
);

// File: tb/tb_cov_engine.sv
module tb_cov_engine;
  localparam int DW = 8;
  localparam int AW = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic done;
  logic mem_req_valid, mem_req_we;
  logic mem_req_ready = 1'b1;
  logic [AW-1:0] mem_req_addr;
  logic [DW-1:0] mem_req_wdata;
  logic mem_rsp_valid = 1'b0;
  logic [DW-1:0] mem_rsp_rdata = '0;

  always #4 clk = ~clk;

  cov_engine #(.DW(DW), .AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_rdata(mem_rsp_rdata)
  );

  logic [7:0] mem [0:1023];
  int xs [256];
  int ys [256];
  int exp_rd [$];
  int exp_wa [$];
  int exp_wd [$];
  logic [7:0] rsp_q [$];
  string cur_tag = "R6";
  int pend_done = 0;
  bit finished = 0;
  bit active = 0;
  bit throttle = 0;
  logic [15:0] lf = 16'hACE1;
  int checks = 0;
  int fails = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference memory and per-clock comparison
  always @(negedge clk) begin
    if (rst_n) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      mem_req_ready = throttle ? (lf[0] | lf[3]) : 1'b1;
      if (rsp_q.size() > 0 && (!throttle || lf[5])) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_rdata = rsp_q.pop_front();
      end else begin
        mem_rsp_valid = 1'b0;
        mem_rsp_rdata = '0;
      end
      #1;
      if (pend_done > 0) begin
        chk(done === 1'b1, "R9 done high", longint'(done), 1);
        pend_done--;
        if (pend_done == 0) finished = 1;
      end else begin
        chk(done === 1'b0, "R9 done low", longint'(done), 0);
      end
      if (mem_req_valid && (!active || done)) chk(0, "R1 R9 request outside run", 1, 0);
      if (mem_req_valid && mem_req_ready && active) begin
        if (mem_req_we) begin
          if (exp_wa.size() == 0) chk(0, "R6 extra write", longint'(mem_req_addr), 0);
          else begin
            int ea, ed;
            ea = exp_wa.pop_front();
            ed = exp_wd.pop_front();
            chk(int'(mem_req_addr) == ea, {cur_tag, " write addr"}, longint'(mem_req_addr), ea);
            chk(int'(mem_req_wdata) == ed, {cur_tag, " write data"}, longint'(mem_req_wdata), ed);
            if (exp_wa.size() == 0) pend_done = 2;
          end
        end else begin
          if (exp_rd.size() == 0) chk(0, "R3 extra read", longint'(mem_req_addr), 0);
          else begin
            int ra;
            ra = exp_rd.pop_front();
            chk(int'(mem_req_addr) == ra, (ra == 0) ? "R2 read addr" : "R3 read addr",
                longint'(mem_req_addr), ra);
          end
          rsp_q.push_back(mem[mem_req_addr]);
        end
      end
    end
  end

  task automatic run_case(input string tag, input int n, input bit thr, input bit toggle);
    longint sx, sy, t, n3, q;
    int tmo;
    sx = 0; sy = 0; t = 0;
    for (int i = 0; i < n; i++) begin sx += xs[i]; sy += ys[i]; end
    for (int i = 0; i < n; i++)
      t += (longint'(n) * xs[i] - sx) * (longint'(n) * ys[i] - sy);
    n3 = longint'(n) * n * n;
    if (t < 0) q = 0;
    else q = (t * 256 + n3 / 2) / n3;
    if (q > 65535) q = 65535;
    mem[0] = 8'((n == 256) ? 0 : n);
    for (int i = 0; i < n; i++) begin
      mem[1 + i] = 8'(xs[i]);
      mem[1 + n + i] = 8'(ys[i]);
    end
    mem[2 * n + 1] = 8'hEE;
    mem[2 * n + 2] = 8'hEE;
    exp_rd.delete(); exp_wa.delete(); exp_wd.delete();
    exp_rd.push_back(0);
    for (int i = 1; i <= n; i++) begin exp_rd.push_back(i); exp_rd.push_back(n + i); end
    exp_wa.push_back(2 * n + 1); exp_wd.push_back(int'(q >> 8));
    exp_wa.push_back(2 * n + 2); exp_wd.push_back(int'(q & 255));
    cur_tag = tag;
    throttle = thr;
    finished = 0;
    active = 1;
    start = 1'b1;
    repeat (3) @(negedge clk);
    start = 1'b0;
    if (toggle) begin
      repeat (20) @(negedge clk);
      start = 1'b1;
      repeat (3) @(negedge clk);
      start = 1'b0;
    end
    tmo = 0;
    while (!finished && tmo < 20000) begin @(negedge clk); tmo++; end
    chk(finished, {tag, " run completes"}, longint'(finished), 1);
    chk(exp_rd.size() == 0, "R3 all samples read", exp_rd.size(), 0);
    @(negedge clk);
    active = 0;
    throttle = 0;
    repeat (10) @(negedge clk);
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk(done === 1'b0 && mem_req_valid === 1'b0, "R10 reset outputs",
        longint'({done, mem_req_valid}), 0);
    rst_n = 1'b1;
    @(negedge clk); #2;
    chk(done === 1'b0 && mem_req_valid === 1'b0, "R10 after reset",
        longint'({done, mem_req_valid}), 0);
    // R6 worked example: result 0x05AB
    xs[0] = 1; xs[1] = 2; xs[2] = 3; ys[0] = 10; ys[1] = 20; ys[2] = 27;
    run_case("R6", 3, 0, 0);
    // R7 negative covariance
    xs[0] = 0; xs[1] = 255; ys[0] = 255; ys[1] = 0;
    run_case("R7", 2, 0, 0);
    // R8 saturation
    xs[0] = 0; xs[1] = 255; ys[0] = 0; ys[1] = 255;
    run_case("R8", 2, 1, 0);
    // R6 single sample gives zero
    xs[0] = 200; ys[0] = 7;
    run_case("R6 N=1", 1, 0, 0);
    // R2 R5 full 256 samples (count byte 0) with stalls on both channels
    for (int i = 0; i < 256; i++) begin xs[i] = i; ys[i] = (i * 7 + 3) & 255; end
    run_case("R2 R5", 256, 1, 0);
    // R1 R4 extra start edge mid-run ignored, stalled requests
    for (int i = 0; i < 20; i++) begin xs[i] = (i * 37 + 11) & 255; ys[i] = (i * i + 5) & 255; end
    run_case("R1 R4", 20, 1, 1);
    // R6 rounding on a small correlated set
    for (int i = 0; i < 7; i++) begin xs[i] = i * 30; ys[i] = (i * 13 + (i & 1) * 9) & 255; end
    run_case("R6 N=7", 7, 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule